// File: doc/BRIEF.md
# Bus Cycle Classifier with Opcode Trace

This block sits beside the bus of an 8-bit processor. Each bus cycle is sorted into one of four kinds: an opcode fetch, an operand fetch, a data access or an internal cycle. Two kinds of processor are supported. One kind gives only a one-bit strobe on opcode fetches. For that kind, the block reads the fetched opcode, works out how many operand bytes follow it and counts them itself. The other kind gives a two-bit pair of valid-data and valid-program flags, which the block passes through as the cycle class.

The class feeds two uses. The first is a select line for a private stack memory. It is high only on the data cycles of a push or pull instruction. The second is a single-step tracer. When tracing is on, the processor is stopped by dropping its ready line after each opcode fetch, and the address of that fetch is stored in a small FIFO. A host reads the FIFO and pulses a step input to let the processor run to its next opcode.

A bus cycle counts as completed at a rising clock edge only when the ready output was high in that cycle. While ready is low, the processor holds its bus and the block's state does not move.

Top module: `bus_cycle_tracer`

## Requirements
- R1: With `pair_mode` high, `cyc_class` equals {`data_vld`,`prog_vld`}. The class codes are 2'b00 internal, 2'b01 operand fetch, 2'b10 data access and 2'b11 opcode fetch.
- R2: With `pair_mode` low, any cycle with `sync_in` high is class 2'b11.
- R3: With `pair_mode` low, the opcode on `data_in` at a completed opcode fetch sets the instruction length from its bits [3:2]: 2'b11 gives 3 bytes, 2'b10 gives 1 byte, and any other value gives 2 bytes. The next length-1 completed non-sync cycles are class 2'b01. Later non-sync cycles are class 2'b10.
- R4: A `sync_in` cycle that arrives while operand bytes are still pending is an opcode fetch. It restarts the length count from the new opcode.
- R5: `stack_cs` is high only on class 2'b10 cycles that follow a completed opcode fetch of 8'h08, 8'h28, 8'h48 or 8'h68. The next completed opcode fetch of any other value clears it.
- R6: While `trace_en` is high, every completed opcode fetch pushes `addr_in` into the trace FIFO (if the FIFO is not full), and `cpu_rdy` is low from the next cycle on.
- R7: While halted, a cycle with `step_in` high and the FIFO not full raises `cpu_rdy` in the following cycle. The held cycle then completes once, with no extra push.
- R8: The trace FIFO holds 16 entries and shows its oldest entry on `fifo_dout`. `fifo_rd` removes that entry at the clock edge. A read while `fifo_empty` is high changes nothing.
- R9: While `fifo_full` is high, `step_in` is ignored and `cpu_rdy` stays low until an entry is read.
- R10: Cycles in which `cpu_rdy` is low do not advance the operand count, the stack flag or the FIFO write side.
- R11: With `trace_en` low, nothing is pushed. Dropping `trace_en` while halted raises `cpu_rdy` in the next cycle.
- R12: After reset, `cpu_rdy` is high, the FIFO is empty, no operand bytes are pending and `stack_cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pair_mode | input | 1 | 1: use the two-bit valid pair; 0: use the sync strobe |
| sync_in | input | 1 | Opcode-fetch strobe (strobe mode) |
| data_vld | input | 1 | Valid data-space access flag (pair mode) |
| prog_vld | input | 1 | Valid program-space access flag (pair mode) |
| addr_in | input | AW | Bus address |
| data_in | input | 8 | Bus data; the opcode on fetch cycles |
| trace_en | input | 1 | Enables halting and address logging |
| step_in | input | 1 | Host pulse that releases a halt |
| fifo_rd | input | 1 | Pops the oldest trace entry |
| cyc_class | output | 2 | Class of the current cycle |
| cpu_rdy | output | 1 | Ready line to the processor; low means halted |
| stack_cs | output | 1 | Select for the private stack memory |
| fifo_dout | output | AW | Oldest trace entry |
| fifo_empty | output | 1 | Trace FIFO empty |
| fifo_full | output | 1 | Trace FIFO full |

## Verification
The bench builds the block with its defaults: a 16-bit address and a 16-entry FIFO. With only sixteen entries, a directed run of sixteen traced opcodes fills the FIFO. This reaches the full-FIFO stall, where steps are refused until the host reads. Random traffic in both input modes mixes halts, steps, reads and stack opcodes, so that reads of an empty FIFO and opcodes cutting into pending operand bytes also occur.

// File: rtl/bus_cycle_tracer.sv
module bus_cycle_tracer #(
  parameter int AW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pair_mode,
  input  logic          sync_in,
  input  logic          data_vld,
  input  logic          prog_vld,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    data_in,
  input  logic          trace_en,
  input  logic          step_in,
  input  logic          fifo_rd,
  output logic [1:0]    cyc_class,
  output logic          cpu_rdy,
  output logic          stack_cs,
  output logic [AW-1:0] fifo_dout,
  output logic          fifo_empty,
  output logic          fifo_full
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [1:0] C_OPR = 2'b01, C_DAT = 2'b10, C_OPC = 2'b11;

  logic [1:0]    pend;
  logic          stk_op, halted;
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic [AW-1:0] mem [DEPTH];

  function automatic logic [1:0] tail_bytes(input logic [7:0] op);
    case (op[3:2])
      2'b11:   tail_bytes = 2'd2;
      2'b10:   tail_bytes = 2'd0;
      default: tail_bytes = 2'd1;
    endcase
  endfunction

  assign cyc_class = pair_mode ? {data_vld, prog_vld} :
                     sync_in   ? C_OPC :
                     (pend != 2'd0) ? C_OPR : C_DAT;

  wire done     = !halted;
  wire opc_done = done && (cyc_class == C_OPC);
  wire is_stack = (data_in & 8'h9F) == 8'h08;

  assign cpu_rdy    = !halted;
  assign stack_cs   = stk_op && (cyc_class == C_DAT);
  assign fifo_empty = (cnt == '0);
  assign fifo_full  = (cnt == (PW+1)'(DEPTH));
  assign fifo_dout  = mem[rp];

  wire push = opc_done && trace_en && !fifo_full;
  wire pop  = fifo_rd && !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      stk_op <= 1'b0;
    end else if (done) begin
      if (cyc_class == C_OPC) begin
        stk_op <= is_stack;
        pend   <= pair_mode ? 2'd0 : tail_bytes(data_in);
      end else if (!pair_mode && pend != 2'd0) begin
        pend <= pend - 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      halted <= 1'b0;
    else if (!trace_en)              halted <= 1'b0;
    else if (opc_done)               halted <= 1'b1;
    else if (step_in && !fifo_full)  halted <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + PW'(1);
      if (pop)  rp <= rp + PW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + (PW+1)'(1);
        2'b01:   cnt <= cnt - (PW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

module bus_cycle_tracer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pair_mode,
  input logic       sync_in,
  input logic [7:0] data_in,
  input logic       trace_en,
  input logic       fifo_rd,
  input logic [1:0] cyc_class,
  input logic       cpu_rdy,
  input logic       stack_cs,
  input logic       fifo_empty,
  input logic       fifo_full
);
  // R3
  opr_after_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_mode && cpu_rdy && sync_in && data_in[3:2] != 2'b10)
      |=> (pair_mode || sync_in || cyc_class == 2'b01));
  // R5
  stk_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_cs |-> cyc_class == 2'b10);
  // R6
  halt_after_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && cpu_rdy && cyc_class == 2'b11) |=> !cpu_rdy);
  // R6
  push_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && cpu_rdy && cyc_class == 2'b11) |=> !fifo_empty);
  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rdy && fifo_full && trace_en && !fifo_rd) |=> !cpu_rdy);
  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && fifo_rd && !(cpu_rdy && trace_en && cyc_class == 2'b11))
      |=> fifo_empty);
endmodule

bind bus_cycle_tracer bus_cycle_tracer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode), .sync_in(sync_in),
  .data_in(data_in), .trace_en(trace_en), .fifo_rd(fifo_rd),
  .cyc_class(cyc_class), .cpu_rdy(cpu_rdy), .stack_cs(stack_cs),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full)
);

// File: tb/sim_bus_cycle_tracer.sv
`timescale 1ns/1ps
module sim_bus_cycle_tracer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pair_mode = 0, sync_in = 0, data_vld = 0, prog_vld = 0;
  logic [15:0] addr_in = '0;
  logic [7:0]  data_in = '0;
  logic trace_en = 0, step_in = 0, fifo_rd = 0;
  logic [1:0]  cyc_class;
  logic cpu_rdy, stack_cs, fifo_empty, fifo_full;
  logic [15:0] fifo_dout;

  always #2.5 clk = ~clk;

  bus_cycle_tracer u0 (.*);

  int n_cmp = 0, n_bad = 0;
  int m_rem = 0;
  bit m_stk = 0, m_halt = 0;
  logic [15:0] q[$];

  function automatic bit stk_op(input logic [7:0] op);
    return op == 8'h08 || op == 8'h28 || op == 8'h48 || op == 8'h68;
  endfunction
  function automatic int op_len(input logic [7:0] op);
    case (op[3:2]) 2'b11: return 3; 2'b10: return 1; default: return 2; endcase
  endfunction
  function automatic logic [1:0] exp_cls();
    if (pair_mode) return {data_vld, prog_vld};
    if (sync_in) return 2'b11;
    return (m_rem > 0) ? 2'b01 : 2'b10;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag = "");
    logic [1:0] ec;
    bit full, done, push;
    #1;
    ec = exp_cls();
    chk(tag != "" ? tag : (pair_mode ? "R1" : "R3"), "class", 32'(cyc_class), 32'(ec));
    chk(tag != "" ? tag : "R6", "rdy", 32'(cpu_rdy), 32'(!m_halt));
    chk(tag != "" ? tag : "R5", "stack_cs", 32'(stack_cs), 32'(m_stk && ec == 2'b10));
    chk(tag != "" ? tag : "R8", "empty", 32'(fifo_empty), 32'(q.size() == 0));
    chk(tag != "" ? tag : "R9", "full", 32'(fifo_full), 32'(q.size() == 16));
    if (q.size() > 0) chk(tag != "" ? tag : "R8", "dout", 32'(fifo_dout), 32'(q[0]));
    full = q.size() == 16;
    done = !m_halt;
    if (done) begin
      if (ec == 2'b11) begin
        m_stk = stk_op(data_in);
        m_rem = pair_mode ? 0 : op_len(data_in) - 1;
      end else if (!pair_mode && m_rem > 0) m_rem--;
    end
    push = done && ec == 2'b11 && trace_en && !full;
    if (fifo_rd && q.size() > 0) void'(q.pop_front());
    if (push) q.push_back(addr_in);
    if (!trace_en) m_halt = 0;
    else if (done && ec == 2'b11) m_halt = 1;
    else if (step_in && !full) m_halt = 0;
    @(negedge clk);
  endtask

  task automatic bus(bit s, logic [15:0] a, logic [7:0] d);
    sync_in = s; addr_in = a; data_in = d;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc("R12");
    // lengths and operand tracking
    bus(1, 16'h1000, 8'hAD); cyc("R2");
    bus(0, 16'h1001, 8'h34); cyc("R3");
    bus(0, 16'h1002, 8'h12); cyc("R3");
    bus(0, 16'h1234, 8'h55); cyc("R3");
    bus(1, 16'h1003, 8'hAD); cyc("R2");
    bus(0, 16'h1004, 8'h00); cyc("R3");
    bus(1, 16'h1005, 8'h48); cyc("R4");
    bus(0, 16'h01FF, 8'h99); cyc("R5");
    bus(1, 16'h1006, 8'hEA); cyc("R5");
    bus(0, 16'h2000, 8'h11); cyc("R5");
    // pair mode
    pair_mode = 1;
    for (int k = 0; k < 4; k++) begin
      {data_vld, prog_vld} = 2'(k); data_in = 8'hEA; cyc("R1");
    end
    {data_vld, prog_vld} = 2'b11; data_in = 8'h68; cyc("R1");
    {data_vld, prog_vld} = 2'b10; cyc("R5");
    {data_vld, prog_vld} = 2'b00; cyc("R5");
    pair_mode = 0;
    // trace and step
    trace_en = 1;
    bus(1, 16'h3000, 8'h48); cyc("R6");
    bus(0, 16'h01FE, 8'h77); cyc("R10");
    cyc("R10");
    step_in = 1; cyc("R7");
    step_in = 0; cyc("R7");
    bus(1, 16'h3001, 8'hA9); cyc("R6");
    bus(0, 16'h3002, 8'h01); cyc("R10");
    trace_en = 0; cyc("R11");
    cyc("R11");
    bus(1, 16'h3003, 8'hEA); cyc("R11");
    bus(0, 16'h3004, 8'h00); fifo_rd = 1; cyc("R8");
    cyc("R8"); cyc("R8");
    fifo_rd = 0; cyc("R8");
    // fill the FIFO
    trace_en = 1;
    for (int i = 0; i < 16; i++) begin
      bus(1, 16'h4000 + 16'(i), 8'hEA); cyc("R9");
      bus(0, 16'h5000, 8'h00); step_in = (i != 15); cyc("R9");
      step_in = 0; if (i != 15) cyc("R9");
    end
    step_in = 1; cyc("R9");
    cyc("R9");
    step_in = 0; fifo_rd = 1; cyc("R9");
    fifo_rd = 0; step_in = 1; cyc("R9");
    step_in = 0; cyc("R7");
    trace_en = 0; fifo_rd = 1;
    repeat (18) cyc("R8");
    fifo_rd = 0;
    // random traffic in both modes
    for (int md = 0; md < 2; md++) begin
      pair_mode = md[0];
      for (int n = 0; n < 1500; n++) begin
        if (!m_halt) begin
          sync_in = ($urandom % 3) == 0;
          {data_vld, prog_vld} = 2'($urandom);
          addr_in = 16'($urandom);
          data_in = ($urandom % 4 == 0) ? {1'b0, 2'($urandom), 5'h08} : 8'($urandom);
        end
        trace_en = ($urandom % 16) != 0;
        step_in  = ($urandom % 4) == 0;
        fifo_rd  = ($urandom % 3) == 0;
        cyc();
      end
    end
    finish_run();
  end
endmodule